// File: doc/BRIEF.md
# Branch-Triggered Block Prefetch Engine

This engine watches retired branches and instruction-cache events and learns which stretch of code tends to miss a fixed number of branches after a given branch. It keeps the addresses of the last five executed branches in a history queue. While a block of code runs after a branch, it tracks the block's first line, counts the cache lines the block references and notes whether any of them missed. When the next branch retires and that block did miss, the block (start line plus length in lines) is linked to the oldest branch in the history. Conditional branches, jumps, calls and returns all count as branches.

Whenever a branch retires, the engine looks its address up in a 16-entry fully associative link table. On a hit it walks the linked block and offers one line prefetch per cycle on a valid/ready output. Before each line is offered, the surrounding cache answers two probe inputs for that line: whether it is already resident, and whether the line's confirmation bit is clear. Either answer drops the line. A new hit while a walk is still running abandons the rest of the old walk. No branch outcome is ever predicted; the lookahead comes only from the depth of the history.

Top module: `branch_block_prefetcher`

## Requirements
- R1: The link written when a branch retires always goes to the branch that retired exactly five branches earlier (the oldest of the five queued). No link is written before five branches have been queued since reset.
- R2: A line address is the byte address with its low 5 bits dropped. A table hit on `br_pc` makes the engine offer lines start, start+1, ..., start+len-1 in ascending order, starting in the cycle after the branch. Each accepted line is followed by the next one.
- R3: The block length is set to 1 in the cycle after a branch. Each `line_ref` pulse in a cycle with no branch adds 1, up to a maximum of 15.
- R4: The miss flag is cleared by a branch and set by `miss_in`. A miss pulse in the same cycle as a branch belongs to the block that starts after that branch.
- R5: When a branch retires with the miss flag clear, the table is left unchanged.
- R6: A link for a branch that already has an entry overwrites that entry's start and length.
- R7: New links take slots in round-robin order over 16 slots. The 17th distinct branch linked after reset evicts the first one.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` does not change, unless a branch retires.
- R9: A line for which `probe_cached` is 1 or `probe_confirmed` is 0 is never offered. It is skipped in one cycle, and the walk goes on with the next line.
- R10: A table hit during a walk discards the remaining lines of that walk. The new block is offered from its first line.
- R11: When the retiring branch is also the oldest queued branch and the miss flag is set, the lookup returns the link as it was before that branch's own update.
- R12: After reset, `pf_valid` is low and the table holds no links.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch retired this cycle |
| br_pc | input | 32 | Byte address of the retired branch |
| br_next_pc | input | 32 | Byte address of the instruction executed after it |
| line_ref | input | 1 | The running code referenced a new cache line |
| miss_in | input | 1 | Instruction-cache miss pulse |
| probe_cached | input | 1 | Line on `pf_line` is already in the cache |
| probe_confirmed | input | 1 | Confirmation bit of the line on `pf_line` |
| pf_valid | output | 1 | A line prefetch request is offered |
| pf_ready | input | 1 | Downstream accepts the request |
| pf_line | output | 27 | Line address of the request or probe |

## Verification
Two things can happen on the same branch edge. A lookup can hit an entry while the update, driven by the oldest queued branch, rewrites that same entry. Also, a miss pulse can coincide with the branch that ends a block. The first case is provoked by retiring a linked branch again when it has reached the head of the history with a missed block pending. The walk must then show the old block, and a later retire must show the new one. The second case is judged by which branch receives the link: the block after the branch, never the block that ended at it.

// File: rtl/bbp_pkg.sv
`timescale 1ns/1ps
package bbp_pkg;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_mode_e;

endpackage

// File: rtl/bbp_history.sv
`timescale 1ns/1ps
// Shift queue holding the most recent branch addresses; index 0 is the oldest.
module bbp_history #(
    parameter int DEPTH = 5,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_pc,
    output logic          head_valid,
    output logic [AW-1:0] head_pc
);

    typedef struct {
        logic [AW-1:0]    pc [DEPTH];
        logic [DEPTH-1:0] vld;
    } hist_t;

    hist_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (push) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.pc[i] = st_q.pc[i+1];
            end
            st_d.pc[DEPTH-1] = push_pc;
            st_d.vld = {1'b1, st_q.vld[DEPTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.pc[i] <= '0;
            end
            st_q.vld <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = st_q.vld[0];
    assign head_pc    = st_q.pc[0];

endmodule

// File: rtl/bbp_table.sv
`timescale 1ns/1ps
// Fully associative link table: branch address -> (start line, length).
module bbp_table #(
    parameter int N_ENT = 16,
    parameter int AW    = 32,
    parameter int LW    = 27,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    look_pc,
    output logic             look_hit,
    output logic [LW-1:0]    look_start,
    output logic [LEN_W-1:0] look_len,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_tag,
    input  logic [LW-1:0]    wr_start,
    input  logic [LEN_W-1:0] wr_len
);

    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct {
        logic [N_ENT-1:0] vld;
        logic [AW-1:0]    tag   [N_ENT];
        logic [LW-1:0]    start [N_ENT];
        logic [LEN_W-1:0] len   [N_ENT];
        logic [IDX_W-1:0] rr;
    } tbl_t;

    tbl_t st_q, st_d;

    logic [N_ENT-1:0] look_match;
    logic [N_ENT-1:0] wr_match;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign look_match[g] = st_q.vld[g] && (st_q.tag[g] == look_pc);
        assign wr_match[g]   = st_q.vld[g] && (st_q.tag[g] == wr_tag);
    end

    // Read port: reflects the table before this cycle's write.
    always_comb begin
        look_hit   = 1'b0;
        look_start = '0;
        look_len   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (look_match[i] && !look_hit) begin
                look_hit   = 1'b1;
                look_start = st_q.start[i];
                look_len   = st_q.len[i];
            end
        end
    end

    logic             wr_found;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        wr_found = 1'b0;
        wr_idx   = st_q.rr;
        for (int i = 0; i < N_ENT; i++) begin
            if (wr_match[i] && !wr_found) begin
                wr_found = 1'b1;
                wr_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx]   = 1'b1;
            st_d.tag[wr_idx]   = wr_tag;
            st_d.start[wr_idx] = wr_start;
            st_d.len[wr_idx]   = wr_len;
            if (!wr_found) begin
                st_d.rr = (st_q.rr == IDX_W'(N_ENT - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= '0;
            for (int i = 0; i < N_ENT; i++) begin
                st_q.tag[i]   <= '0;
                st_q.start[i] <= '0;
                st_q.len[i]   <= '0;
            end
            st_q.rr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bbp_reqgen.sv
`timescale 1ns/1ps
// Walks a linked block one line per cycle, dropping probed-out lines.
module bbp_reqgen
    import bbp_pkg::*;
#(
    parameter int LW    = 27,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LW-1:0]    load_line,
    input  logic [LEN_W-1:0] load_len,
    input  logic             probe_cached,
    input  logic             probe_confirmed,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [LW-1:0]    pf_line
);

    typedef struct packed {
        gen_mode_e        mode;
        logic [LW-1:0]    line;
        logic [LEN_W-1:0] left;
    } gen_t;

    gen_t st_q, st_d;

    logic running;
    logic drop;
    logic step;

    assign running  = (st_q.mode == GEN_RUN);
    assign drop     = probe_cached || !probe_confirmed;
    assign pf_valid = running && !drop;
    assign pf_line  = st_q.line;
    assign step     = running && (drop || pf_ready);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.mode = GEN_RUN;
            st_d.line = load_line;
            st_d.left = load_len;
        end else if (step) begin
            st_d.line = st_q.line + 1'b1;
            st_d.left = st_q.left - 1'b1;
            if (st_q.left <= LEN_W'(1)) begin
                st_d.mode = GEN_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: GEN_IDLE, line: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/branch_block_prefetcher.sv
`timescale 1ns/1ps
module branch_block_prefetcher #(
    parameter int AW       = 32,
    parameter int LINE_OFF = 5,
    parameter int HIST_N   = 5,
    parameter int TBL_N    = 16,
    parameter int LEN_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   br_valid,
    input  logic [AW-1:0]          br_pc,
    input  logic [AW-1:0]          br_next_pc,
    input  logic                   line_ref,
    input  logic                   miss_in,
    input  logic                   probe_cached,
    input  logic                   probe_confirmed,
    output logic                   pf_valid,
    input  logic                   pf_ready,
    output logic [AW-LINE_OFF-1:0] pf_line
);

    localparam int LW = AW - LINE_OFF;

    typedef struct packed {
        logic [LW-1:0]    start;
        logic [LEN_W-1:0] len;
        logic             miss;
    } track_t;

    track_t tr_q, tr_d;

    logic [LW-1:0]    start_q;
    logic [LEN_W-1:0] len_q;
    logic             miss_q;

    assign start_q = tr_q.start;
    assign len_q   = tr_q.len;
    assign miss_q  = tr_q.miss;

    always_comb begin
        tr_d = tr_q;
        if (br_valid) begin
            tr_d.start = br_next_pc[AW-1:LINE_OFF];
            tr_d.len   = LEN_W'(1);
            tr_d.miss  = miss_in;
        end else begin
            if (line_ref && (tr_q.len != '1)) begin
                tr_d.len = tr_q.len + 1'b1;
            end
            if (miss_in) begin
                tr_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= '{start: '0, len: '0, miss: 1'b0};
        end else begin
            tr_q <= tr_d;
        end
    end

    logic          head_valid;
    logic [AW-1:0] head_pc;

    bbp_history #(
        .DEPTH (HIST_N),
        .AW    (AW)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (br_valid),
        .push_pc    (br_pc),
        .head_valid (head_valid),
        .head_pc    (head_pc)
    );

    logic             look_hit;
    logic [LW-1:0]    look_start;
    logic [LEN_W-1:0] look_len;
    logic             link_wr;

    assign link_wr = br_valid && miss_q && head_valid;

    bbp_table #(
        .N_ENT (TBL_N),
        .AW    (AW),
        .LW    (LW),
        .LEN_W (LEN_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_pc    (br_pc),
        .look_hit   (look_hit),
        .look_start (look_start),
        .look_len   (look_len),
        .wr_en      (link_wr),
        .wr_tag     (head_pc),
        .wr_start   (start_q),
        .wr_len     (len_q)
    );

    bbp_reqgen #(
        .LW    (LW),
        .LEN_W (LEN_W)
    ) u_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .load            (br_valid && look_hit),
        .load_line       (look_start),
        .load_len        (look_len),
        .probe_cached    (probe_cached),
        .probe_confirmed (probe_confirmed),
        .pf_valid        (pf_valid),
        .pf_ready        (pf_ready),
        .pf_line         (pf_line)
    );

endmodule

// File: rtl/bbp_checker.sv
`timescale 1ns/1ps
module bbp_checker #(
    parameter int LW    = 27,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_valid,
    input logic             miss_in,
    input logic             pf_valid,
    input logic             pf_ready,
    input logic [LW-1:0]    pf_line,
    input logic             miss_q,
    input logic [LEN_W-1:0] len_q
);

    // R8: a stalled request keeps its line
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready && !br_valid |=> pf_valid && $stable(pf_line));

    // R2: the request after an accepted one is the next line
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && !br_valid |=> !pf_valid || (pf_line == $past(pf_line) + 1'b1));

    // R4: branch without a coincident miss leaves the flag clear
    a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && !miss_in |=> !miss_q);

    // R4: a miss between branches raises the flag
    a_r4_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid && miss_in |=> miss_q);

    // R3: length restarts at one after each branch
    a_r3_len_restart: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> len_q == LEN_W'(1));

endmodule

bind branch_block_prefetcher bbp_checker #(
    .LW    (AW - LINE_OFF),
    .LEN_W (LEN_W)
) u_bbp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_valid (br_valid),
    .miss_in  (miss_in),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_line  (pf_line),
    .miss_q   (miss_q),
    .len_q    (len_q)
);

// File: tb/tb_branch_block_prefetcher.sv
`timescale 1ns/1ps
module tb_branch_block_prefetcher;

    localparam int AW = 32;
    localparam int LW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_pc = '0;
    logic [AW-1:0] br_next_pc = '0;
    logic          line_ref = 1'b0;
    logic          miss_in = 1'b0;
    logic          probe_cached;
    logic          probe_confirmed;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [LW-1:0] pf_line;

    logic [LW-1:0] cached_line = '1;
    logic [LW-1:0] noconf_line = '1;

    assign probe_cached    = (pf_line == cached_line);
    assign probe_confirmed = (pf_line != noconf_line);

    always #2.5 clk = ~clk;

    branch_block_prefetcher dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .br_valid        (br_valid),
        .br_pc           (br_pc),
        .br_next_pc      (br_next_pc),
        .line_ref        (line_ref),
        .miss_in         (miss_in),
        .probe_cached    (probe_cached),
        .probe_confirmed (probe_confirmed),
        .pf_valid        (pf_valid),
        .pf_ready        (pf_ready),
        .pf_line         (pf_line)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [LW-1:0] got   [32];
    int            got_n;
    logic [LW-1:0] exp_l [32];
    int            exp_n;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; br_valid = 1'b0; line_ref = 1'b0; miss_in = 1'b0;
        pf_ready = 1'b1; cached_line = '1; noconf_line = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic branch(input logic [AW-1:0] pc, input logic [AW-1:0] npc, input bit with_miss);
        @(negedge clk);
        br_valid = 1'b1; br_pc = pc; br_next_pc = npc; miss_in = with_miss;
        @(negedge clk);
        br_valid = 1'b0; miss_in = 1'b0;
    endtask

    task automatic ref_lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_ref = 1'b1;
            @(negedge clk); line_ref = 1'b0;
        end
    endtask

    task automatic miss_pulse();
        @(negedge clk); miss_in = 1'b1;
        @(negedge clk); miss_in = 1'b0;
    endtask

    task automatic collect(input int ncyc);
        got_n = 0;
        for (int c = 0; c < ncyc; c++) begin
            if (pf_valid && pf_ready && got_n < 32) begin
                got[got_n] = pf_line;
                got_n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic set_run(input logic [LW-1:0] first, input int n);
        exp_n = n;
        for (int i = 0; i < n; i++) exp_l[i] = first + LW'(i);
    endtask

    task automatic compare(input string r);
        chk({r, " count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk({r, " line"}, got[i], exp_l[i]);
        end
    endtask

    // Five branches from base, a block at npc, then a sixth branch that links base.
    task automatic train(input logic [AW-1:0] base, input logic [AW-1:0] npc,
                         input int refs, input bit with_miss);
        for (int i = 0; i < 5; i++) begin
            branch(base + AW'(i*64), (i == 4) ? npc : base + AW'(i*64 + 4), 1'b0);
        end
        ref_lines(refs);
        if (with_miss) miss_pulse();
        branch(base + AW'(5*64), base + AW'(5*64 + 4), 1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_basic();
        reset_dut();
        chk("R12 pf_valid after reset", pf_valid, 1'b0);
        branch(32'h1000, 32'h1004, 1'b0);
        chk("R12 no walk on empty table", pf_valid, 1'b0);
        reset_dut();
        train(32'h1000, 32'h8000, 2, 1'b1);
        branch(32'h1000, 32'h1004, 1'b0);
        collect(10);
        set_run(27'h400, 3); compare("R2 R3 linked block");
        branch(32'h1040, 32'h1044, 1'b0);
        collect(6);
        set_run(27'h0, 0); compare("R1 second branch not linked");
    endtask

    task automatic t_no_miss();
        reset_dut();
        train(32'h1000, 32'h8000, 2, 1'b0);
        branch(32'h1000, 32'h1004, 1'b0);
        collect(6);
        set_run(27'h0, 0); compare("R5 no link without miss");
    endtask

    task automatic t_same_cycle_miss();
        reset_dut();
        for (int i = 0; i < 5; i++) begin
            branch(32'h1000 + AW'(i*64), (i == 4) ? 32'h8000 : 32'h1004 + AW'(i*64), 1'b0);
        end
        branch(32'h1140, 32'h9000, 1'b1);
        branch(32'h1180, 32'h1184, 1'b0);
        repeat (2) @(negedge clk);
        branch(32'h1000, 32'h1004, 1'b0);
        collect(6);
        set_run(27'h0, 0); compare("R4 coincident miss not in ending block");
        branch(32'h1040, 32'h1044, 1'b0);
        collect(6);
        set_run(27'h480, 1); compare("R4 coincident miss in new block");
    endtask

    task automatic t_saturate();
        reset_dut();
        train(32'h1000, 32'h8000, 20, 1'b1);
        branch(32'h1000, 32'h1004, 1'b0);
        collect(24);
        set_run(27'h400, 15); compare("R3 length saturates at 15");
    endtask

    task automatic t_backpressure();
        reset_dut();
        train(32'h1000, 32'h8000, 2, 1'b1);
        pf_ready = 1'b0;
        branch(32'h1000, 32'h1004, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 valid held", pf_valid, 1'b1);
        chk("R8 line held", pf_line, 27'h400);
        pf_ready = 1'b1;
        collect(8);
        set_run(27'h400, 3); compare("R8 after release");
    endtask

    task automatic t_suppress();
        reset_dut();
        train(32'h1000, 32'h8000, 3, 1'b1);
        cached_line = 27'h401;
        noconf_line = 27'h403;
        branch(32'h1000, 32'h1004, 1'b0);
        collect(10);
        exp_n = 2; exp_l[0] = 27'h400; exp_l[1] = 27'h402;
        compare("R9 cached and unconfirmed dropped");
        cached_line = '1; noconf_line = '1;
    endtask

    task automatic t_replace();
        reset_dut();
        train(32'h1000, 32'h8000, 7, 1'b1);
        train(32'h3000, 32'hA000, 1, 1'b1);
        pf_ready = 1'b0;
        branch(32'h1000, 32'h1004, 1'b0);
        chk("R10 first walk started", pf_line, 27'h400);
        branch(32'h3000, 32'h3004, 1'b0);
        chk("R10 new walk at first line", pf_line, 27'h500);
        pf_ready = 1'b1;
        collect(12);
        set_run(27'h500, 2); compare("R10 old walk discarded");
    endtask

    task automatic t_same_entry();
        reset_dut();
        train(32'h1000, 32'h8000, 2, 1'b1);
        branch(32'h1000, 32'h1004, 1'b0);
        collect(8);
        set_run(27'h400, 3); compare("R2 before overwrite");
        for (int i = 1; i < 5; i++) begin
            branch(32'h5000 + AW'(i*64), (i == 4) ? 32'hC000 : 32'h5004 + AW'(i*64), 1'b0);
        end
        miss_pulse();
        branch(32'h1000, 32'h1004, 1'b0);
        collect(8);
        set_run(27'h400, 3); compare("R11 lookup sees old link");
        branch(32'h1000, 32'h1004, 1'b0);
        collect(8);
        set_run(27'h600, 1); compare("R6 link overwritten");
    endtask

    task automatic t_evict();
        reset_dut();
        for (int i = 0; i < 22; i++) begin
            branch(32'h2000 + AW'(i*16), 32'h40000 + AW'(i*256), 1'b0);
            if (i >= 4 && i <= 20) miss_pulse();
        end
        repeat (2) @(negedge clk);
        branch(32'h2000, 32'h2004, 1'b0);
        collect(6);
        set_run(27'h0, 0); compare("R7 first link evicted");
        branch(32'h2010, 32'h2014, 1'b0);
        collect(6);
        set_run(27'h2028, 1); compare("R7 second link kept");
        branch(32'h2100, 32'h2104, 1'b0);
        collect(6);
        set_run(27'h20A0, 1); compare("R7 seventeenth link present");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        t_basic();
        t_no_miss();
        t_same_cycle_miss();
        t_saturate();
        t_backpressure();
        t_suppress();
        t_replace();
        t_same_entry();
        t_evict();
        done = 1'b1;
        summary();
    end

endmodule